// File: doc/BRIEF.md
# GPIO Bank Register File with Masked-Write Aliases

This block holds the control state of one GPIO bank of 32 pins, grouped as four ports of eight pins. For each port it keeps a mode-select (GPIO configuration) byte, an output-enable byte, an output-data byte, an interrupt-enable byte and an interrupt-type byte. It also offers a synchronized view of the pin inputs. A simple word-addressed bus reads and writes these registers. The block drives the pad output and output-enable lines and hands the interrupt enable and type bits to a separate detector.

Every writable register appears a second time in an alias window. A write there carries a per-pin write mask in data bits [15:8] and the new pin values in bits [7:0]. One bus write can therefore set or clear any subset of a port's pins, and the other pins of the port are left untouched, so software never needs a read-modify-write. The bank's position in the address map and the alias window offset are parameters. Two layouts are intended: stride 0x80 with alias offset 0x800, and stride 0x100 with alias offset 0x80.

Top module: `gpio_bank_regs`

## Requirements
- R1: Plain registers sit at byte address BANK_IDX*BANK_STRIDE + group offset + 4*port. The address's bits [1:0] are ignored. Group offsets are: configuration 0x00, output enable 0x10, output data 0x20, input level 0x30, interrupt status 0x40, interrupt enable 0x50, interrupt type 0x60, interrupt clear 0x70. Port p covers global pins 8p..8p+7, and bit n of a register is pin 8p+n.
- R2: A write to the alias window (plain address + ALIAS_OFS) of a configuration, output-enable, output-data, interrupt-enable or interrupt-type register changes only the pins n whose data bit 8+n is 1, and sets each such pin to data bit n. A write with a zero mask changes nothing.
- R3: A plain write to a writable register replaces all eight pins with data bits [7:0]. Data bits [31:8] are ignored.
- R4: Pin i drives pinOe[i]=1 only when its configuration bit and its output-enable bit are both 1. pinOut[i] equals the output-data bit while the pin is driven and is 0 otherwise. Pad outputs change only in the cycle after a register write.
- R5: The input-level register returns pinIn through a two-flop synchronizer. A level applied before clock edge k is returned by a read whose sampling edge is k+2 or later, and a read sampled at edge k or k+1 still returns the old level.
- R6: The input-level register and the interrupt status and clear offsets cannot be written, neither by plain nor by alias writes. Reads of the status and clear offsets return zero.
- R7: After reset every register is zero: all interrupts are disabled, all pads are undriven and pinOut is 0.
- R8: Reads of addresses outside the bank's plain window, and reads of the alias window, return zero. Writes outside both windows change nothing.
- R9: busRvalid is 1 exactly in the cycle after a cycle with busRe=1, and busRdata holds the read data in that cycle.
- R10: intEnable and intType present each port's interrupt-enable and interrupt-type bytes at pin positions, and they update in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWe | input | 1 | Write request |
| busRe | input | 1 | Read request |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | DATA_W | Write data; mask in [15:8] for alias writes |
| busRdata | output | DATA_W | Read data, valid with busRvalid |
| busRvalid | output | 1 | Read data valid, one cycle after busRe |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Pin drive values |
| pinOe | output | 32 | Pin drive enables |
| intEnable | output | 32 | Per-pin interrupt enable to the detector |
| intType | output | 32 | Per-pin interrupt type to the detector |

## Verification
Corrupted register state reaches the ports quickly. It shows on pinOut, pinOe, intEnable or intType in the cycle after the write that caused it, and on busRdata one cycle after the next read of that register. A misrouted write, such as an alias write that clobbers unmasked pins or a decode that ignores the bank base, appears as a wrong pad byte or a wrong read-back byte on a port the stimulus did not address. A fault in the synchronizer shows as input data that arrives one edge early or one edge late, and the bench places reads on the exact edges that tell these cases apart.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int PORT_SEL_W = 2;
  localparam int N_PORTS    = 1 << PORT_SEL_W;

  // register group, taken from byte-offset bits [6:4]
  typedef enum logic [2:0] {
    GRP_CFG  = 3'd0,
    GRP_OE   = 3'd1,
    GRP_OUT  = 3'd2,
    GRP_IN   = 3'd3,
    GRP_ISTA = 3'd4,
    GRP_IEN  = 3'd5,
    GRP_ITYP = 3'd6,
    GRP_ICLR = 3'd7
  } regGrp_e;

  // decoded access from control to datapath
  typedef struct packed {
    logic                  wr;      // write hits a writable register
    logic                  rd;      // a read was requested
    logic                  rdHit;   // the read hits a readable register
    logic                  masked;  // access is in the alias window
    regGrp_e               grp;
    logic [PORT_SEL_W-1:0] port;
  } busStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BANK_IDX    = 1,
  parameter int BANK_STRIDE = 128,
  parameter int ALIAS_OFS   = 2048
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strb
);

  localparam int GROUP_SPAN = 128;
  localparam logic [ADDR_W-1:0] PLAIN_BASE = ADDR_W'(BANK_IDX * BANK_STRIDE);
  localparam logic [ADDR_W-1:0] ALIAS_BASE = ADDR_W'(BANK_IDX * BANK_STRIDE + ALIAS_OFS);

  logic [ADDR_W-1:0] plainRel;
  logic [ADDR_W-1:0] aliasRel;
  logic [4:0]        relSel;
  logic              inPlain;
  logic              inAlias;
  logic              writable;
  logic              readable;
  regGrp_e           grp;

  always_comb begin
    plainRel = busAddr - PLAIN_BASE;
    aliasRel = busAddr - ALIAS_BASE;
    inPlain  = plainRel < ADDR_W'(GROUP_SPAN);
    inAlias  = aliasRel < ADDR_W'(GROUP_SPAN);
    relSel   = inPlain ? plainRel[6:2] : aliasRel[6:2];
    grp      = regGrp_e'(relSel[4:2]);

    unique case (grp)
      GRP_CFG, GRP_OE, GRP_OUT, GRP_IEN, GRP_ITYP: writable = 1'b1;
      default:                                   writable = 1'b0;
    endcase
    unique case (grp)
      GRP_ISTA, GRP_ICLR: readable = 1'b0;
      default:            readable = 1'b1;
    endcase

    strb.wr     = busWe & (inPlain | inAlias) & writable;
    strb.rd     = busRe;
    strb.rdHit  = busRe & inPlain & readable;
    strb.masked = inAlias & ~inPlain;
    strb.grp    = grp;
    strb.port   = relSel[1:0];
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PORT_W = 8,
  localparam int PINS  = N_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  busStrobe_t        strb,
  input  logic [2*PORT_W-1:0] wrData,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic [PINS-1:0]   intEnable,
  output logic [PINS-1:0]   intType,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [PORT_W-1:0] wrVal;
  logic [PORT_W-1:0] wrMask;
  assign wrVal  = wrData[PORT_W-1:0];
  assign wrMask = wrData[2*PORT_W-1:PORT_W];

  function automatic logic [PORT_W-1:0] mergeByte(
    input logic [PORT_W-1:0] old,
    input logic [PORT_W-1:0] val,
    input logic [PORT_W-1:0] msk,
    input logic              useMask
  );
    return useMask ? ((old & ~msk) | (val & msk)) : val;
  endfunction

  logic [PORT_W-1:0] cfgV [N_PORTS];
  logic [PORT_W-1:0] oeV  [N_PORTS];
  logic [PORT_W-1:0] outV [N_PORTS];
  logic [PORT_W-1:0] ienV [N_PORTS];
  logic [PORT_W-1:0] ityV [N_PORTS];

  for (genvar p = 0; p < N_PORTS; p++) begin : gPort
    logic [PORT_W-1:0] cfgQ, oeQ, outQ, ienQ, ityQ;
    logic sel;
    assign sel = strb.wr && (strb.port == PORT_SEL_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfgQ <= '0;
        oeQ  <= '0;
        outQ <= '0;
        ienQ <= '0;
        ityQ <= '0;
      end else if (sel) begin
        unique case (strb.grp)
          GRP_CFG:  cfgQ <= mergeByte(cfgQ, wrVal, wrMask, strb.masked);
          GRP_OE:   oeQ  <= mergeByte(oeQ,  wrVal, wrMask, strb.masked);
          GRP_OUT:  outQ <= mergeByte(outQ, wrVal, wrMask, strb.masked);
          GRP_IEN:  ienQ <= mergeByte(ienQ, wrVal, wrMask, strb.masked);
          GRP_ITYP: ityQ <= mergeByte(ityQ, wrVal, wrMask, strb.masked);
          default: ;
        endcase
      end
    end

    assign cfgV[p] = cfgQ;
    assign oeV[p]  = oeQ;
    assign outV[p] = outQ;
    assign ienV[p] = ienQ;
    assign ityV[p] = ityQ;

    assign pinOe[p*PORT_W +: PORT_W]     = cfgQ & oeQ;
    assign pinOut[p*PORT_W +: PORT_W]    = outQ & cfgQ & oeQ;
    assign intEnable[p*PORT_W +: PORT_W] = ienQ;
    assign intType[p*PORT_W +: PORT_W]   = ityQ;
  end

  // two-flop input synchronizer
  logic [PINS-1:0] syncA, syncB;
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  logic [PORT_W-1:0] rdByte;
  always_comb begin
    unique case (strb.grp)
      GRP_CFG:  rdByte = cfgV[strb.port];
      GRP_OE:   rdByte = oeV[strb.port];
      GRP_OUT:  rdByte = outV[strb.port];
      GRP_IN:   rdByte = syncB[strb.port*PORT_W +: PORT_W];
      GRP_IEN:  rdByte = ienV[strb.port];
      GRP_ITYP: rdByte = ityV[strb.port];
      default:  rdByte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rd;
      if (strb.rd) rdData <= strb.rdHit ? DATA_W'(rdByte) : '0;
    end
  end

  // pin-position views of the current write, used by the checks below
  logic [PINS-1:0] wideMask, wideVal, wideField;
  assign wideMask  = PINS'(wrMask) << (strb.port * PORT_W);
  assign wideVal   = PINS'(wrVal) << (strb.port * PORT_W);
  assign wideField = PINS'({PORT_W{1'b1}}) << (strb.port * PORT_W);

  p_masked_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (strb.wr && strb.masked && strb.grp == GRP_OUT)
      |=> (((pinOut ^ $past(pinOut)) & ~$past(wideMask)) == '0))
    else $error("R2: masked write touched an unmasked pin");

  p_quiet_pads_r4: assert property (@(posedge clk) disable iff (rst)
    !strb.wr |=> ($stable(pinOut) && $stable(pinOe)))
    else $error("R4: pad outputs changed without a write");

  p_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
    strb.rd |=> rdValid)
    else $error("R9: read not answered");

  p_no_spurious_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
    !strb.rd |=> !rdValid)
    else $error("R9: valid without read");

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (strb.rd && !strb.rdHit) |=> (rdData == '0))
    else $error("R8: unmapped read returned nonzero");

  p_ien_plain_r10: assert property (@(posedge clk) disable iff (rst)
    (strb.wr && !strb.masked && strb.grp == GRP_IEN)
      |=> (intEnable == (($past(intEnable) & ~$past(wideField)) | $past(wideVal))))
    else $error("R10: interrupt enable not updated");

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int PORT_W      = 8,
  parameter int BANK_IDX    = 1,
  parameter int BANK_STRIDE = 128,
  parameter int ALIAS_OFS   = 2048,
  localparam int PINS       = N_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic [PINS-1:0]   intEnable,
  output logic [PINS-1:0]   intType
);

  busStrobe_t strb;
  logic unusedWdataHi;
  assign unusedWdataHi = ^busWdata[DATA_W-1:2*PORT_W];

  gpio_bank_ctrl #(
    .ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX),
    .BANK_STRIDE(BANK_STRIDE), .ALIAS_OFS(ALIAS_OFS)
  ) u_ctrl (
    .busWe(busWe), .busRe(busRe), .busAddr(busAddr), .strb(strb)
  );

  gpio_bank_dp #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .wrData(busWdata[2*PORT_W-1:0]), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe),
    .intEnable(intEnable), .intType(intType),
    .rdData(busRdata), .rdValid(busRvalid)
  );

endmodule

// File: tb/tb_gpio_bank_regs.sv
`timescale 1ns/1ps
module tb_gpio_bank_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe, intEnable, intType;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  gpio_bank_regs dut (
    .clk(clk), .rst(rst), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .intEnable(intEnable), .intType(intType)
  );

  task automatic checkEq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic expectRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  // monitor: compares read results as they come out
  always @(negedge clk) begin
    if (!rst && busRvalid) begin
      if (expQ.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R9: unexpected valid, actual %h expected none", busRdata);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkEq(busRdata, e, t);
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  // plain base 0x080, alias base 0x880 with default parameters
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkEq(pinOut, 32'h0, "R7 pinOut reset");
    checkEq(pinOe, 32'h0, "R7 pinOe reset");
    checkEq(intEnable, 32'h0, "R7 intEnable reset");
    checkEq(intType, 32'h0, "R7 intType reset");
    checkEq({31'h0, busRvalid}, 32'h0, "R9 idle valid");
    expectRead(12'h080, 32'h0, "R7 cfg reset read");

    // R3 / R4 plain writes on port 0
    busWrite(12'h080, 32'h0000_00FF);
    busWrite(12'h090, 32'h0000_000F);
    busWrite(12'h0A0, 32'h0000_00A5);
    checkEq(pinOe, 32'h0000_000F, "R4 oe gated by cfg");
    checkEq(pinOut, 32'h0000_0005, "R4 out gated");
    expectRead(12'h0A0, 32'h0000_00A5, "R1 out readback");
    busWrite(12'h084, 32'h1234_56C3);
    expectRead(12'h084, 32'h0000_00C3, "R3 upper bits ignored");

    // R2 masked alias writes
    busWrite(12'h8A0, 32'h0000_0F0A);
    expectRead(12'h0A0, 32'h0000_00AA, "R2 masked merge");
    checkEq(pinOut, 32'h0000_000A, "R2 pad after masked write");
    busWrite(12'h8A0, 32'h0000_00FF);
    expectRead(12'h0A0, 32'h0000_00AA, "R2 zero mask no change");

    // R4 port 3 through aliases, port 2 without configuration
    busWrite(12'h88C, 32'h0000_FFFF);
    busWrite(12'h89C, 32'h0000_8080);
    busWrite(12'h0AC, 32'h0000_00FF);
    busWrite(12'h098, 32'h0000_00FF);
    busWrite(12'h0A8, 32'h0000_00FF);
    checkEq(pinOe, 32'h8000_000F, "R4 oe ports 2 and 3");
    checkEq(pinOut, 32'h8000_000A, "R4 out ports 2 and 3");

    // R10 interrupt registers
    busWrite(12'h0D4, 32'h0000_003C);
    checkEq(intEnable, 32'h0000_3C00, "R10 ien plain");
    busWrite(12'h8D4, 32'h0000_0101);
    checkEq(intEnable, 32'h0000_3D00, "R10 ien masked");
    busWrite(12'h8E8, 32'h0000_F0F0);
    checkEq(intType, 32'h00F0_0000, "R10 itype masked");
    expectRead(12'h0E8, 32'h0000_00F0, "R1 itype readback");

    // R5 synchronizer latency: old, old, new
    @(negedge clk);
    pinIn = 32'hDEAD_BEEF; busRe = 1'b1; busAddr = 12'h0B0;
    expQ.push_back(32'h0); tagQ.push_back("R5 edge k");
    @(negedge clk);
    expQ.push_back(32'h0); tagQ.push_back("R5 edge k+1");
    @(negedge clk);
    expQ.push_back(32'hEF); tagQ.push_back("R5 edge k+2");
    @(negedge clk);
    busRe = 1'b0;
    expectRead(12'h0BC, 32'h0000_00DE, "R5 port 3 level");

    // R6 read-only and reserved offsets
    busWrite(12'h0B0, 32'h0000_0000);
    busWrite(12'h8B0, 32'h0000_FF00);
    expectRead(12'h0B0, 32'h0000_00EF, "R6 input not writable");
    busWrite(12'h0C0, 32'h0000_00FF);
    busWrite(12'h0F0, 32'h0000_00FF);
    busWrite(12'h8F0, 32'h0000_FFFF);
    expectRead(12'h0C0, 32'h0, "R6 status reads zero");
    expectRead(12'h0F0, 32'h0, "R6 clear reads zero");
    checkEq(pinOut, 32'h8000_000A, "R6 pads untouched");

    // R8 outside the bank
    busWrite(12'h004, 32'h0000_0000);
    busWrite(12'h100, 32'h0000_0000);
    expectRead(12'h084, 32'h0000_00C3, "R8 write outside ignored");
    expectRead(12'h000, 32'h0, "R8 read below bank");
    expectRead(12'h8A0, 32'h0, "R8 alias read zero");
    checkEq(intEnable, 32'h0000_3D00, "R8 ien untouched");

    repeat (3) @(negedge clk);
    checkEq(expQ.size(), 32'h0, "R9 all reads answered");
    done = 1'b1;
    report();
  end

endmodule